// File: doc/BRIEF.md
# Periodic Routed Interrupt Timer

This block is a down-counting timer with a small memory-mapped register set. Software programs a 28-bit period and two enable bits, and gives a 3-bit route. While running, the timer counts qualified reference ticks. Each time a full period has elapsed it raises a sticky interrupt flag, reloads itself and keeps counting. The flag holds until software clears it through a separate acknowledge register. The same register can also restart the current period.

The interrupt is level-sensitive. While the flag and the interrupt enable are both set, it shows up as one bit in the interrupt source vector of exactly one processor core. The route decides which core, and whether the bit goes to that core's normal (IRQ) vector or its fast (FIQ) vector. A tick-enable input sets the count rate. In the target system it pulses at a 38.4 MHz rate.

Top module: `lt_periodic_top`

## Requirements
- R1: After reset, the route register and the control register read as zero, the interrupt flag is clear, the counter is stopped and every bit of both source vectors is 0.
- R2: The registers are at byte offsets 0x24 (route), 0x34 (control) and 0x38 (acknowledge). The route register reads back its 3 stored bits with zeros above them. The control register reads bit 31 = interrupt flag, and bits 30:0 as last written: bit 30 restart-request, bit 29 interrupt enable, bit 28 timer enable, bits 27:0 period. The acknowledge register and every other offset read 0, and writes to other offsets change nothing.
- R3: With the timer enable set and a period N > 0, the flag sets on the N-th cycle with tick_en high after the countdown starts, and again every N ticks after that. The counter does not move on cycles with tick_en low.
- R4: A control write with bit 28 set starts a fresh countdown from the newly written period. A control write with bit 28 clear stops the counter, and no flag is raised while it is stopped.
- R5: An acknowledge write with bit 31 set clears the flag. An acknowledge write with bit 30 set restarts the countdown from the stored period, but only while the timer enable is set.
- R6: If an expiry and an acknowledge clear happen in the same cycle, the flag ends up set.
- R7: With a period of zero the timer never raises the flag, even when enabled.
- R8: The routed interrupt stays asserted on every cycle while both the flag and the interrupt enable (bit 29) are set, and is deasserted otherwise.
- R9: Route bits 1:0 pick the core (0 to 3). Route bit 2 = 1 selects the FIQ vector and 0 selects the IRQ vector. Each core has a 12-bit vector, and core c occupies bits c*12+11 down to c*12 of the flattened bus. The interrupt appears only in bit 11 of the chosen core's chosen vector. Every other bit of both buses stays 0.
- R10: A control write does not change the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Reference tick qualifier; the counter advances only when high |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq_src | output | N_CORES*SRC_W (48) | Per-core IRQ source vectors, core c in bits c*12 +: 12 |
| fiq_src | output | N_CORES*SRC_W (48) | Per-core FIQ source vectors, same layout |

## Verification
The bench targets the period boundary. A design that reloads one tick early or one tick late would raise the flag on the wrong tick, and one that counts without tick_en would drift. It collides an expiry with an acknowledge clear in the same cycle, where a design with the wrong priority silently drops an interrupt. It also runs a zero period with the timer enabled, where a careless compare would fire on every tick. It steers the interrupt to both IRQ and FIQ on different cores, so a swapped select bit or a wrong slice offset lights the wrong bit. It checks that a control write leaves the flag intact and that a restart request has no effect while the timer is disabled.

// File: rtl/lt_pkg.sv
package lt_pkg;

  localparam int unsigned REG_DW   = 32;
  localparam int unsigned PERIOD_W = 28;

  localparam int unsigned OFS_ROUTE = 'h24;
  localparam int unsigned OFS_CTRL  = 'h34;
  localparam int unsigned OFS_ACK   = 'h38;

  localparam int unsigned BIT_FLAG    = 31;
  localparam int unsigned BIT_RESTART = 30;
  localparam int unsigned BIT_IE      = 29;
  localparam int unsigned BIT_EN      = 28;

  typedef struct packed {
    logic                expire;
    logic [PERIOD_W-1:0] next;
  } step_t;

  // One qualified tick of the countdown: expiry when one tick remains.
  function automatic step_t count_step(input logic [PERIOD_W-1:0] cur,
                                       input logic [PERIOD_W-1:0] period);
    step_t s;
    if (period == '0) begin
      s.expire = 1'b0;
      s.next   = cur;
    end else if (cur <= PERIOD_W'(1)) begin
      s.expire = 1'b1;
      s.next   = period;
    end else begin
      s.expire = 1'b0;
      s.next   = cur - PERIOD_W'(1);
    end
    return s;
  endfunction

  // Flattened bit position of a source bit for a given core.
  function automatic int unsigned src_pos(input int unsigned core,
                                          input int unsigned src_w,
                                          input int unsigned bitpos);
    return core * src_w + bitpos;
  endfunction

endpackage

// File: rtl/lt_regs.sv
module lt_regs #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned ROUTE_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [lt_pkg::REG_DW-1:0]   wdata_i,
  input  logic                        expire_i,
  output logic [lt_pkg::REG_DW-1:0]   rdata_o,
  output logic [ROUTE_W-1:0]          route_o,
  output logic                        run_en_o,
  output logic                        int_en_o,
  output logic                        flag_o,
  output logic                        restart_o,
  output logic [lt_pkg::PERIOD_W-1:0] load_val_o,
  output logic [lt_pkg::PERIOD_W-1:0] period_o
);
  import lt_pkg::*;

  localparam int unsigned CTRL_W = REG_DW - 1;

  logic [ROUTE_W-1:0] route_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               flag_q;

  logic hit_route, hit_ctrl, hit_ack;
  logic route_wr, ctrl_wr, ack_wr;
  logic ack_clr_w, ack_rst_w;

  assign hit_route = (addr_i == ADDR_W'(OFS_ROUTE));
  assign hit_ctrl  = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_ack   = (addr_i == ADDR_W'(OFS_ACK));

  assign route_wr  = wr_en_i && hit_route;
  assign ctrl_wr   = wr_en_i && hit_ctrl;
  assign ack_wr    = wr_en_i && hit_ack;

  assign ack_clr_w = ack_wr && wdata_i[BIT_FLAG];
  assign ack_rst_w = ack_wr && wdata_i[BIT_RESTART] && ctrl_q[BIT_EN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= '0;
      ctrl_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (route_wr) route_q <= wdata_i[ROUTE_W-1:0];
      if (ctrl_wr)  ctrl_q  <= wdata_i[CTRL_W-1:0];
      if (expire_i)       flag_q <= 1'b1;
      else if (ack_clr_w) flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_route)     rdata_o = REG_DW'(route_q);
    else if (hit_ctrl) rdata_o = {flag_q, ctrl_q};
  end

  assign route_o    = route_q;
  assign run_en_o   = ctrl_q[BIT_EN];
  assign int_en_o   = ctrl_q[BIT_IE];
  assign flag_o     = flag_q;
  assign period_o   = ctrl_q[PERIOD_W-1:0];
  assign restart_o  = ctrl_wr || ack_rst_w;
  assign load_val_o = ctrl_wr ? wdata_i[PERIOD_W-1:0] : ctrl_q[PERIOD_W-1:0];

  assert_flag_rise_from_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(expire_i));

  assert_flag_fall_from_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(ack_clr_w));

  assert_ctrl_write_keeps_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !expire_i && !ack_clr_w) |=> (flag_q == $past(flag_q)));

endmodule

// File: rtl/lt_countdown.sv
module lt_countdown (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick_en_i,
  input  logic                        run_en_i,
  input  logic                        restart_i,
  input  logic [lt_pkg::PERIOD_W-1:0] load_val_i,
  input  logic [lt_pkg::PERIOD_W-1:0] period_i,
  output logic                        expire_o
);
  import lt_pkg::*;

  logic [PERIOD_W-1:0] cnt_q;
  step_t               step_w;
  logic                advance_w;

  assign step_w    = count_step(cnt_q, period_i);
  assign advance_w = run_en_i && tick_en_i && !restart_i;
  assign expire_o  = advance_w && step_w.expire;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= load_val_i;
    else if (advance_w) cnt_q <= step_w.next;
  end

  assert_expire_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (run_en_i && tick_en_i));

  assert_zero_period_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i == '0) |-> !expire_o);

  assert_stopped_counter_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lt_route.sv
module lt_route #(
  parameter int unsigned N_CORES   = 4,
  parameter int unsigned CORE_W    = 2,
  parameter int unsigned SRC_W     = 12,
  parameter int unsigned TIMER_BIT = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active_i,
  input  logic [CORE_W:0]          route_i,
  output logic [N_CORES*SRC_W-1:0] irq_src_o,
  output logic [N_CORES*SRC_W-1:0] fiq_src_o
);
  localparam logic [SRC_W-1:0] SRC_MASK = {{(SRC_W-1){1'b0}}, 1'b1} << TIMER_BIT;

  logic use_fiq;
  assign use_fiq = route_i[CORE_W];

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic hit;
    assign hit = active_i && (route_i[CORE_W-1:0] == CORE_W'(c));
    assign irq_src_o[c*SRC_W +: SRC_W] = (hit && !use_fiq) ? SRC_MASK : '0;
    assign fiq_src_o[c*SRC_W +: SRC_W] = (hit &&  use_fiq) ? SRC_MASK : '0;
  end

  assert_single_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_src_o, fiq_src_o}));

endmodule

// File: rtl/lt_periodic_top.sv
module lt_periodic_top #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned N_CORES   = 4,
  parameter int unsigned SRC_W     = 12,
  parameter int unsigned TIMER_BIT = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_en,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [N_CORES*SRC_W-1:0]  irq_src,
  output logic [N_CORES*SRC_W-1:0]  fiq_src
);
  import lt_pkg::*;

  localparam int unsigned CORE_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1;
  localparam int unsigned ROUTE_W = CORE_W + 1;

  logic [ROUTE_W-1:0]  route_w;
  logic                run_en_w, int_en_w, flag_w, restart_w, expire_w;
  logic [PERIOD_W-1:0] load_val_w, period_w;
  logic                active_w;

  lt_regs #(.ADDR_W(ADDR_W), .ROUTE_W(ROUTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .expire_i(expire_w), .rdata_o(rdata), .route_o(route_w), .run_en_o(run_en_w),
    .int_en_o(int_en_w), .flag_o(flag_w), .restart_o(restart_w),
    .load_val_o(load_val_w), .period_o(period_w)
  );

  lt_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .run_en_i(run_en_w),
    .restart_i(restart_w), .load_val_i(load_val_w), .period_i(period_w),
    .expire_o(expire_w)
  );

  assign active_w = flag_w && int_en_w;

  lt_route #(.N_CORES(N_CORES), .CORE_W(CORE_W), .SRC_W(SRC_W), .TIMER_BIT(TIMER_BIT)) u_route (
    .clk(clk), .rst_n(rst_n), .active_i(active_w), .route_i(route_w),
    .irq_src_o(irq_src), .fiq_src_o(fiq_src)
  );

  assert_level_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w && int_en_w) |-> (|{irq_src, fiq_src}));

endmodule

// File: tb/test_lt_periodic_top.sv
module test_lt_periodic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [47:0] irq_src, fiq_src;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [2:0]  m_route = '0;
  logic [30:0] m_ctrl = '0;
  logic        m_flag = 1'b0;
  logic [27:0] m_left = '0;
  logic [31:0] last_rdata;
  logic [47:0] last_irq, last_fiq;

  always #4 clk = ~clk;

  lt_periodic_top i_lt_periodic_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_src(irq_src), .fiq_src(fiq_src)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h24:   return {29'd0, m_route};
      8'h34:   return {m_flag, m_ctrl};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [47:0] exp_vec(input bit want_fiq);
    logic [47:0] v = '0;
    if (m_flag && m_ctrl[29] && (m_route[2] == want_fiq))
      v[int'(m_route[1:0]) * 12 + 11] = 1'b1;
    return v;
  endfunction

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
    logic go_restart, fire;
    logic [27:0] per;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; tick_en = t;
    #1;
    last_rdata = rdata; last_irq = irq_src; last_fiq = fiq_src;
    chk("R2 read data", {32'd0, rdata}, {32'd0, exp_read(a)});
    chk("R9 irq vector", {16'd0, irq_src}, {16'd0, exp_vec(0)});
    chk("R9 fiq vector", {16'd0, fiq_src}, {16'd0, exp_vec(1)});
    per = m_ctrl[27:0];
    go_restart = w && ((a == 8'h34) || (a == 8'h38 && d[30] && m_ctrl[28]));
    fire = !go_restart && m_ctrl[28] && t && (per != 0) && (m_left < 2);
    @(posedge clk);
    if (go_restart)                 m_left = (a == 8'h34) ? d[27:0] : per;
    else if (m_ctrl[28] && t && per != 0) m_left = fire ? per : m_left - 1;
    if (fire) m_flag = 1'b1;
    else if (w && a == 8'h38 && d[31]) m_flag = 1'b0;
    if (w && a == 8'h34) m_ctrl = d[30:0];
    if (w && a == 8'h24) m_route = d[2:0];
  endtask

  task automatic idle(input logic [7:0] a, input logic t);
    step(1'b0, a, 32'd0, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    idle(8'h34, 0); chk("R1 control after reset", {32'd0, last_rdata}, 64'd0);
    idle(8'h24, 0); chk("R1 route after reset", {32'd0, last_rdata}, 64'd0);
    chk("R1 vectors after reset", {16'd0, last_irq | last_fiq}, 64'd0);

    // R2 route keeps 3 bits; ack and unmapped read zero; unmapped write ignored
    step(1, 8'h24, 32'hFFFF_FFF5, 0);
    step(1, 8'h40, 32'hFFFF_FFFF, 0);
    idle(8'h24, 0); chk("R2 route readback", {32'd0, last_rdata}, 64'd5);
    idle(8'h38, 0); chk("R2 ack reads zero", {32'd0, last_rdata}, 64'd0);
    idle(8'h34, 0); chk("R2 unmapped write ignored", {32'd0, last_rdata}, 64'd0);

    // R3 period of 4 ticks, route 5 = core1 FIQ (bit 23)
    step(1, 8'h34, 32'h3000_0004, 1);
    idle(8'h34, 0);                       // no tick: counter must not move
    repeat (3) idle(8'h34, 1);
    chk("R3 no flag before 4th tick", {16'd0, last_fiq}, 64'd0);
    idle(8'h34, 1);
    chk("R3 no flag on sample of 4th tick", {16'd0, last_fiq}, 64'd0);
    idle(8'h34, 0);
    chk("R9 core1 fiq bit 23", {16'd0, last_fiq}, 64'd1 << 23);
    chk("R9 irq quiet on fiq route", {16'd0, last_irq}, 64'd0);
    repeat (10) idle(8'h34, 0);
    chk("R8 level held", {16'd0, last_fiq}, 64'd1 << 23);

    // R10 control write keeps flag
    step(1, 8'h34, 32'h3000_0004, 0);
    idle(8'h34, 0); chk("R10 flag kept", {63'd0, last_rdata[31]}, 64'd1);

    // R5 clear via ack
    step(1, 8'h38, 32'h8000_0000, 0);
    idle(8'h34, 0); chk("R5 flag cleared", {63'd0, last_rdata[31]}, 64'd0);
    chk("R8 deasserted", {16'd0, last_fiq}, 64'd0);

    // R5 restart via ack bit 30
    step(1, 8'h34, 32'h3000_0004, 0);
    repeat (2) idle(8'h34, 1);
    step(1, 8'h38, 32'h4000_0000, 1);
    repeat (3) idle(8'h34, 1);
    idle(8'h34, 0); chk("R5 restart delays expiry", {63'd0, last_rdata[31]}, 64'd0);
    idle(8'h34, 1); idle(8'h34, 0);
    chk("R5 expiry after restart", {63'd0, last_rdata[31]}, 64'd1);

    // R6 expiry and clear in the same cycle
    step(1, 8'h34, 32'h3000_0002, 0);
    idle(8'h34, 1);
    step(1, 8'h38, 32'h8000_0000, 1);
    idle(8'h34, 0); chk("R6 set wins over clear", {63'd0, last_rdata[31]}, 64'd1);

    // R4 stopped timer; R5 restart ignored while disabled
    step(1, 8'h38, 32'h8000_0000, 0);
    step(1, 8'h34, 32'h2000_0002, 0);
    step(1, 8'h38, 32'h4000_0000, 1);
    repeat (10) idle(8'h34, 1);
    idle(8'h34, 0); chk("R4 stopped never flags", {63'd0, last_rdata[31]}, 64'd0);

    // R7 zero period
    step(1, 8'h34, 32'h3000_0000, 0);
    repeat (20) idle(8'h34, 1);
    idle(8'h34, 0); chk("R7 zero period silent", {63'd0, last_rdata[31]}, 64'd0);

    // R9 route 3 = core3 IRQ (bit 47)
    step(1, 8'h24, 32'd3, 0);
    step(1, 8'h34, 32'h3000_0001, 0);
    idle(8'h34, 1); idle(8'h34, 0);
    chk("R9 core3 irq bit 47", {16'd0, last_irq}, 64'd1 << 47);
    step(1, 8'h38, 32'h8000_0000, 0);

    // random phase against the bench model
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel = $urandom % 16;
      logic t = 1'($urandom % 2);
      logic [31:0] d = $urandom;
      case (sel)
        0, 1: begin
          d[27:0] = 28'($urandom % 8);
          d[28]   = ($urandom % 8) != 0;
          step(1, 8'h34, d, t);
        end
        2, 3:    step(1, 8'h38, d, t);
        4:       step(1, 8'h24, d, t);
        5:       step(1, 8'h44, d, t);
        default: idle((sel[0]) ? 8'h34 : 8'h24, t);
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule